// File: doc/BRIEF.md
# Pixel Overlay and Blanking Selector

This block sits between a colour palette and the video output stage. On each pixel clock it picks one of three sources for the 4-bit-per-component RGB value that leaves it: the palette colour, a text colour built from four text bits, or the all-zero blanking level. A display-period enable forces blanking outside the active area. An overlay select swaps the palette for text. A mask input blanks the palette path.

Text colour has two rendering styles. In white-balance style, any lit text pixel becomes a grey of the chosen strength. In enhancement style, only the components whose text bit is set carry that strength. The strength comes from a 2-bit weight plus a brightness bit. All inputs are sampled on the pixel clock and the result is registered, so the output is one clock behind the inputs. This matches the latency of a registered palette.

Top module: `pxsel_top`

## Requirements
- R1: With `disp_en`=1, `ovl_sel`=0 and `pal_keep`=1, the output equals the palette colour `pal_r/pal_g/pal_b`.
- R2: With `disp_en`=0, all three output components are 0, whatever the other inputs are.
- R3: With `disp_en`=1 and `ovl_sel`=1, the output is the text colour, and `pal_keep` has no effect.
- R4: With `disp_en`=1, `ovl_sel`=0 and `pal_keep`=0, all three output components are 0.
- R5: The text strength is 4 × `txt_w` + 3 × `txt_hi`, clamped to 15. `txt_w` is an unsigned binary code: 00→0, 01→1, 10→2, 11→3.
- R6: When `txt_wb`=1 (white balance), a text pixel with at least one of `txt_r/txt_g/txt_b` set drives all three components to the strength. A pixel with none set drives 0.
- R7: When `txt_wb`=0 (enhancement), each component drives the strength if its own text bit is set, and 0 otherwise.
- R8: The output changes only on a rising clock edge. It reflects the inputs sampled at the previous rising edge, which is one clock of latency.
- R9: While `rst_n` is 0, all output components are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pal_r | input | 4 | Palette red |
| pal_g | input | 4 | Palette green |
| pal_b | input | 4 | Palette blue |
| pal_keep | input | 1 | 1 = pass the palette, 0 = blank the palette path |
| disp_en | input | 1 | 1 = active display period, 0 = force blanking |
| ovl_sel | input | 1 | 1 = text colour, 0 = palette path |
| txt_r | input | 1 | Text red bit |
| txt_g | input | 1 | Text green bit |
| txt_b | input | 1 | Text blue bit |
| txt_hi | input | 1 | Text brightness bit |
| txt_wb | input | 1 | 1 = white balance, 0 = enhancement |
| txt_w | input | 2 | Text weight code |
| out_r | output | 4 | Registered output red |
| out_g | output | 4 | Registered output green |
| out_b | output | 4 | Registered output blue |

## Verification
The bench targets the priority corners where several controls disagree:
- Blanking must override an active overlay. A design that ranked the overlay first would paint text into the border.
- The overlay with the mask low must still show text. A design that applied the mask after the overlay would blank it.

It also walks the full weight and brightness range, so an off-by-one or a swapped weight bit shows up as a wrong level. It compares single-bit text pixels across the two styles, which catches a design that spreads or fails to spread the level to the dark components. Finally, it samples just before an edge after changing the inputs, so a design missing the output register is exposed.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

  parameter int unsigned PX_CW    = 4;
  parameter int unsigned PX_WW    = 2;
  parameter int unsigned PX_WSTEP = 4;
  parameter int unsigned PX_ISTEP = 3;

  typedef enum logic [1:0] {
    SRC_BLANK = 2'd0,
    SRC_PAL   = 2'd1,
    SRC_TEXT  = 2'd2
  } src_e;

  // text strength: weight steps plus optional brightness step, clamped
  function automatic int unsigned shade_level(
    input int unsigned w,
    input logic        hi,
    input int unsigned wstep,
    input int unsigned istep,
    input int unsigned cmax
  );
    int unsigned s;
    s = w * wstep + (hi ? istep : 0);
    return (s > cmax) ? cmax : s;
  endfunction

endpackage

// File: rtl/pxsel_text_shade.sv
module pxsel_text_shade #(
  parameter int unsigned CW    = pxsel_pkg::PX_CW,
  parameter int unsigned WW    = pxsel_pkg::PX_WW,
  parameter int unsigned WSTEP = pxsel_pkg::PX_WSTEP,
  parameter int unsigned ISTEP = pxsel_pkg::PX_ISTEP
) (
  input  logic [2:0]          bits,
  input  logic                hi,
  input  logic                wb,
  input  logic [WW-1:0]       weight,
  output logic                lit,
  output logic [CW-1:0]       level,
  output logic [2:0][CW-1:0]  shade
);
  localparam int unsigned CMAX = (1 << CW) - 1;

  logic [2:0] comp_on;

  assign lit   = |bits;
  assign level = CW'(pxsel_pkg::shade_level(32'(weight), hi, WSTEP, ISTEP, CMAX));

  for (genvar c = 0; c < 3; c++) begin : g_comp
    assign comp_on[c] = wb ? lit : bits[c];
    assign shade[c]   = comp_on[c] ? level : '0;
  end
endmodule

// File: rtl/pxsel_src_arb.sv
module pxsel_src_arb (
  input  logic              disp_en,
  input  logic              ovl_sel,
  input  logic              pal_keep,
  output pxsel_pkg::src_e   src
);
  always_comb begin
    if (!disp_en)      src = pxsel_pkg::SRC_BLANK;
    else if (ovl_sel)  src = pxsel_pkg::SRC_TEXT;
    else if (pal_keep) src = pxsel_pkg::SRC_PAL;
    else               src = pxsel_pkg::SRC_BLANK;
  end
endmodule

// File: rtl/pxsel_chan.sv
module pxsel_chan #(
  parameter int unsigned CW = pxsel_pkg::PX_CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pxsel_pkg::src_e   src,
  input  logic [CW-1:0]     pal,
  input  logic [CW-1:0]     txt,
  output logic [CW-1:0]     q
);
  logic [CW-1:0] nxt;

  always_comb begin
    case (src)
      pxsel_pkg::SRC_PAL:  nxt = pal;
      pxsel_pkg::SRC_TEXT: nxt = txt;
      default:             nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/pxsel_top.sv
module pxsel_top #(
  parameter int unsigned CW    = pxsel_pkg::PX_CW,
  parameter int unsigned WW    = pxsel_pkg::PX_WW,
  parameter int unsigned WSTEP = pxsel_pkg::PX_WSTEP,
  parameter int unsigned ISTEP = pxsel_pkg::PX_ISTEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pal_r,
  input  logic [CW-1:0] pal_g,
  input  logic [CW-1:0] pal_b,
  input  logic          pal_keep,
  input  logic          disp_en,
  input  logic          ovl_sel,
  input  logic          txt_r,
  input  logic          txt_g,
  input  logic          txt_b,
  input  logic          txt_hi,
  input  logic          txt_wb,
  input  logic [WW-1:0] txt_w,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);
  // index 2 = red, 1 = green, 0 = blue
  logic [2:0][CW-1:0] pal_vec;
  logic [2:0][CW-1:0] shade_rgb;
  logic [2:0][CW-1:0] out_vec;
  logic [CW-1:0]      shade_lvl;
  logic               text_lit;
  pxsel_pkg::src_e    src_sel;

  assign pal_vec = {pal_r, pal_g, pal_b};

  pxsel_text_shade #(.CW(CW), .WW(WW), .WSTEP(WSTEP), .ISTEP(ISTEP)) u_shade (
    .bits   ({txt_r, txt_g, txt_b}),
    .hi     (txt_hi),
    .wb     (txt_wb),
    .weight (txt_w),
    .lit    (text_lit),
    .level  (shade_lvl),
    .shade  (shade_rgb)
  );

  pxsel_src_arb u_arb (
    .disp_en  (disp_en),
    .ovl_sel  (ovl_sel),
    .pal_keep (pal_keep),
    .src      (src_sel)
  );

  for (genvar c = 0; c < 3; c++) begin : g_chan
    pxsel_chan #(.CW(CW)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_sel),
      .pal   (pal_vec[c]),
      .txt   (shade_rgb[c]),
      .q     (out_vec[c])
    );
  end

  assign out_r = out_vec[2];
  assign out_g = out_vec[1];
  assign out_b = out_vec[0];
endmodule

// File: rtl/pxsel_chk.sv
module pxsel_chk #(
  parameter int unsigned CW = pxsel_pkg::PX_CW,
  parameter int unsigned WW = pxsel_pkg::PX_WW
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      pal_r,
  input logic [CW-1:0]      pal_g,
  input logic [CW-1:0]      pal_b,
  input logic               pal_keep,
  input logic               disp_en,
  input logic               ovl_sel,
  input logic               txt_r,
  input logic               txt_hi,
  input logic               txt_wb,
  input logic [WW-1:0]      txt_w,
  input logic [2:0][CW-1:0] shade_rgb,
  input logic [CW-1:0]      out_r,
  input logic [CW-1:0]      out_g,
  input logic [CW-1:0]      out_b
);
  localparam logic [CW-1:0] CMAX = '1;

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R2
  disp_blank_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !$past(disp_en) |-> (out_r == '0 && out_g == '0 && out_b == '0));

  // R4
  mask_blank_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(disp_en && !ovl_sel && !pal_keep) |-> (out_r == '0 && out_g == '0 && out_b == '0));

  // R1
  pal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(disp_en && !ovl_sel && pal_keep) |->
      (out_r == $past(pal_r) && out_g == $past(pal_g) && out_b == $past(pal_b)));

  // R3
  text_route_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(disp_en && ovl_sel) |-> ({out_r, out_g, out_b} == $past(shade_rgb)));

  // R6
  wb_grey_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(disp_en && ovl_sel && txt_wb) |-> (out_r == out_g && out_g == out_b));

  // R7
  enh_dark_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(disp_en && ovl_sel && !txt_wb && !txt_r) |-> (out_r == '0));

  // R5
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(disp_en && ovl_sel && txt_r && txt_hi && (txt_w == '1)) |-> (out_r == CMAX));
endmodule

bind pxsel_top pxsel_chk #(.CW(CW), .WW(WW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pal_r     (pal_r),
  .pal_g     (pal_g),
  .pal_b     (pal_b),
  .pal_keep  (pal_keep),
  .disp_en   (disp_en),
  .ovl_sel   (ovl_sel),
  .txt_r     (txt_r),
  .txt_hi    (txt_hi),
  .txt_wb    (txt_wb),
  .txt_w     (txt_w),
  .shade_rgb (shade_rgb),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b)
);

// File: tb/tb_pxsel_top.sv
module tb_pxsel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pal_r = '0, pal_g = '0, pal_b = '0;
  logic       pal_keep = 1'b0, disp_en = 1'b0, ovl_sel = 1'b0;
  logic       txt_r = 1'b0, txt_g = 1'b0, txt_b = 1'b0, txt_hi = 1'b0, txt_wb = 1'b0;
  logic [1:0] txt_w = '0;
  logic [3:0] out_r, out_g, out_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_q = '0;

  always #10 clk = ~clk;

  pxsel_top dut (
    .clk(clk), .rst_n(rst_n), .pal_r(pal_r), .pal_g(pal_g), .pal_b(pal_b),
    .pal_keep(pal_keep), .disp_en(disp_en), .ovl_sel(ovl_sel),
    .txt_r(txt_r), .txt_g(txt_g), .txt_b(txt_b), .txt_hi(txt_hi),
    .txt_wb(txt_wb), .txt_w(txt_w), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // strength by repeated addition, clamped (R5)
  function automatic logic [3:0] strength(input logic [1:0] w, input logic hi);
    int acc = 0;
    for (int k = 0; k < int'(w); k++) acc += 4;
    if (hi) acc += 3;
    if (acc > 15) acc = 15;
    return 4'(acc);
  endfunction

  function automatic logic [11:0] model();
    logic [3:0] s;
    logic any;
    s = strength(txt_w, txt_hi);
    any = txt_r | txt_g | txt_b;
    if (!disp_en) return 12'h000;
    if (ovl_sel) begin
      if (txt_wb) return any ? {s, s, s} : 12'h000;
      return {txt_r ? s : 4'h0, txt_g ? s : 4'h0, txt_b ? s : 4'h0};
    end
    if (!pal_keep) return 12'h000;
    return {pal_r, pal_g, pal_b};
  endfunction

  function automatic string tag_of();
    if (!disp_en) return "R2";
    if (ovl_sel) return txt_wb ? "R6" : "R7";
    if (!pal_keep) return "R4";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [11:0] exp);
    n_chk++;
    if ({out_r, out_g, out_b} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, {out_r, out_g, out_b}, exp);
    end
  endtask

  // drive at negedge, check at next negedge
  task automatic apply(input string tag);
    exp_q = model();
    @(negedge clk);
    check(tag, exp_q);
  endtask

  task automatic set_all(input logic d, o, m, wb, r, g, b, hi, input logic [1:0] w,
                         input logic [11:0] pal);
    disp_en = d; ovl_sel = o; pal_keep = m; txt_wb = wb;
    txt_r = r; txt_g = g; txt_b = b; txt_hi = hi; txt_w = w;
    {pal_r, pal_g, pal_b} = pal;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed));
    // R9: reset holds zero even with active palette inputs
    set_all(1, 0, 1, 0, 0, 0, 0, 0, 2'd0, 12'hABC);
    repeat (3) @(negedge clk);
    check("R9", 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed palette pass
    set_all(1, 0, 1, 0, 1, 1, 1, 1, 2'd3, 12'h5A3);
    apply("R1");
    // R4 mask blanks palette
    set_all(1, 0, 0, 0, 1, 0, 0, 1, 2'd3, 12'hFFF);
    apply("R4");
    // R2 display off beats overlay
    set_all(0, 1, 1, 1, 1, 1, 1, 1, 2'd3, 12'hFFF);
    apply("R2");
    // R3 overlay with mask low still shows text
    set_all(1, 1, 0, 0, 0, 1, 0, 0, 2'd2, 12'h123);
    apply("R3");
    // R5 full weight range, both brightness values
    for (int w = 0; w < 4; w++) begin
      for (int h = 0; h < 2; h++) begin
        set_all(1, 1, 1, 0, 1, 0, 0, h[0], w[1:0], 12'h000);
        apply("R5");
      end
    end
    // R6 white balance: single bit lights all, no bits gives zero
    set_all(1, 1, 1, 1, 0, 0, 1, 1, 2'd1, 12'h777);
    apply("R6");
    set_all(1, 1, 1, 1, 0, 0, 0, 1, 2'd3, 12'h777);
    apply("R6");
    // R7 enhancement: same pixel only lights blue
    set_all(1, 1, 1, 0, 0, 0, 1, 1, 2'd1, 12'h777);
    apply("R7");
    // R8 latency: change inputs, output holds until the edge
    set_all(1, 0, 1, 0, 0, 0, 0, 0, 2'd0, 12'h9E1);
    exp_q = model();
    @(posedge clk);
    @(negedge clk);
    set_all(1, 0, 1, 0, 0, 0, 0, 0, 2'd0, 12'h246);
    #9;
    check("R8", 12'h9E1);
    @(negedge clk);
    check("R8", 12'h246);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      set_all(rv[0] | rv[1] | rv[2], rv[3], rv[4] | rv[5], rv[6], rv[7], rv[8], rv[9],
              rv[10], rv[12:11], rv[31:20]);
      apply(tag_of());
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule